// File: doc/BRIEF.md
# Bus-Error Exception Precision Controller

This block sits next to the load/store unit of a simple in-order pipeline. It decides how a bus-access error, which can arrive any number of cycles after the access starts, becomes a trap. A single run-time mode bit chooses between two behaviours. In precise mode, issue is frozen for as long as a memory access is outstanding, so the trap names the faulting load/store. In imprecise mode, independent non-memory instructions keep flowing. The trap then names whatever instruction occupies the execute stage when the error comes back.

Whatever the mode, a protection (PMP) violation found when the access starts is trapped precisely. The trap-value output always holds the exact address of the access that failed. The mode bit is written through a CSR write port: address 0x7C5, bit 20. A change requested while an access is outstanding is held back until that access finishes.

The controller is a four-state machine:
- `ST_IDLE`: no access outstanding.
- `ST_WAIT_PREC`: an access is outstanding in precise mode.
- `ST_WAIT_IMPR`: an access is outstanding in imprecise mode.
- `ST_TRAP`: a one-cycle trap pulse.

Its transitions are:
- accept (IDLE to WAIT_PREC or WAIT_IMPR, chosen by the current mode).
- pmp_reject (IDLE to TRAP).
- bus_ok (WAIT to IDLE).
- bus_fail (WAIT to TRAP).
- retire (TRAP to IDLE).

Top module: `buserr_precision_ctrl`

## Requirements
- R1: After reset, `precise_mode` is 1, `issue_stall` is 0 and `trap_valid` is 0.
- R2: A CSR write with `csr_addr` = 0x7C5 made while no access is outstanding sets the mode to `csr_wdata[20]`, visible on `precise_mode` from the next cycle. A write to any other address has no effect.
- R3: In precise mode, `issue_stall` is 1 from the cycle after an accepted `ls_start` through the cycle in which `ls_done` or `ls_err` arrives. It is 0 while idle.
- R4: In imprecise mode, while the access is outstanding, `issue_stall` equals `next_is_ls | next_dep`.
- R5: In precise mode, an `ls_err` raises `trap_valid` in the next cycle, with `trap_epc` equal to the `ls_pc` given at the start of the access.
- R6: In imprecise mode, an `ls_err` raises `trap_valid` in the next cycle, with `trap_epc` equal to the `ex_pc` present in the error cycle.
- R7: An `ls_start` with `pmp_fault` set, in either mode, raises `trap_valid` in the next cycle with `trap_epc` equal to that `ls_pc`. No outstanding wait is entered.
- R8: For every trap, `trap_tval` equals the faulting access's `ls_addr`. `trap_cause` is 5 for a load and 7 for a store, where `ls_store` = 1 marks a store.
- R9: `trap_valid` lasts exactly one cycle and `issue_stall` is 1 during it. In the following cycle both are 0.
- R10: A mode write made while an access is outstanding leaves `precise_mode` and the stall rule unchanged until the access completes. The new mode shows in the cycle after completion.
- R11: An `ls_done` without `ls_err` produces no trap, and `issue_stall` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR write address |
| csr_wdata | input | 32 | CSR write data; bit 20 is the mode |
| ls_start | input | 1 | Load/store starts this cycle (taken only when idle) |
| ls_store | input | 1 | Starting access is a store |
| ls_pc | input | 32 | PC of the starting access |
| ls_addr | input | 32 | Address of the starting access |
| pmp_fault | input | 1 | Protection violation on the starting access |
| ls_done | input | 1 | Bus response OK for the outstanding access |
| ls_err | input | 1 | Bus error for the outstanding access |
| next_is_ls | input | 1 | Instruction waiting to issue is a load/store |
| next_dep | input | 1 | Instruction waiting to issue depends on the access |
| ex_pc | input | 32 | PC currently in the execute stage |
| issue_stall | output | 1 | Hold issue |
| precise_mode | output | 1 | Mode in effect (1 = precise) |
| trap_valid | output | 1 | One-cycle trap request |
| trap_epc | output | 32 | Exception PC |
| trap_tval | output | 32 | Faulting address |
| trap_cause | output | 4 | Exception cause code |

## Verification
A stuck or wrong state shows at the ports in the same cycle through `issue_stall`. An idle-versus-waiting mix-up breaks the stall rule at once. A wrong wait flavour makes the stall follow or ignore the decode flags. A bad capture register shows one cycle after the error or PMP reject, as a wrong `trap_epc`, `trap_tval` or `trap_cause`. A mishandled pending mode write shows on `precise_mode` either during the outstanding window or in the first idle cycle after it.

// File: rtl/bep_pkg.sv
package bep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_PREC = 2'd1,
        ST_WAIT_IMPR = 2'd2,
        ST_TRAP      = 2'd3
    } bep_state_e;

    localparam int unsigned CAUSE_LOAD_ACCESS  = 5;
    localparam int unsigned CAUSE_STORE_ACCESS = 7;

endpackage

// File: rtl/bep_mode_reg.sv
module bep_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic busy,
    output logic mode_eff
);
    logic mode_q;
    logic pend_q;
    logic pend_val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= 1'b1;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b1;
        end else if (wr_en) begin
            if (busy) begin
                pend_q     <= 1'b1;
                pend_val_q <= wr_val;
            end else begin
                mode_q <= wr_val;
                pend_q <= 1'b0;
            end
        end else if (!busy && pend_q) begin
            mode_q <= pend_val_q;
            pend_q <= 1'b0;
        end
    end

    // A deferred value becomes visible in the first cycle without an access
    assign mode_eff = (pend_q && !busy) ? pend_val_q : mode_q;

endmodule

// File: rtl/bep_fault_latch.sv
module bep_fault_latch #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [XLEN-1:0]    cap_pc,
    input  logic [XLEN-1:0]    cap_addr,
    input  logic               cap_store,
    input  logic               fire,
    input  logic               use_now,
    input  logic               use_ex,
    input  logic [XLEN-1:0]    ex_pc,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    tval,
    output logic [CAUSE_W-1:0] cause
);
    import bep_pkg::*;

    localparam logic [CAUSE_W-1:0] C_LOAD  = CAUSE_W'(CAUSE_LOAD_ACCESS);
    localparam logic [CAUSE_W-1:0] C_STORE = CAUSE_W'(CAUSE_STORE_ACCESS);

    logic [XLEN-1:0] acc_pc_q;
    logic [XLEN-1:0] acc_addr_q;
    logic            acc_store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_pc_q    <= '0;
            acc_addr_q  <= '0;
            acc_store_q <= 1'b0;
        end else if (cap_en) begin
            acc_pc_q    <= cap_pc;
            acc_addr_q  <= cap_addr;
            acc_store_q <= cap_store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc   <= '0;
            tval  <= '0;
            cause <= '0;
        end else if (fire) begin
            if (use_now) begin
                epc   <= cap_pc;
                tval  <= cap_addr;
                cause <= cap_store ? C_STORE : C_LOAD;
            end else begin
                epc   <= use_ex ? ex_pc : acc_pc_q;
                tval  <= acc_addr_q;
                cause <= acc_store_q ? C_STORE : C_LOAD;
            end
        end
    end

endmodule

// File: rtl/buserr_precision_ctrl.sv
module buserr_precision_ctrl #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned CSR_AW    = 12,
    parameter logic [11:0] HINT_ADDR = 12'h7C5,
    parameter int unsigned MODE_BIT  = 20,
    parameter int unsigned CAUSE_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    input  logic               ls_start,
    input  logic               ls_store,
    input  logic [XLEN-1:0]    ls_pc,
    input  logic [XLEN-1:0]    ls_addr,
    input  logic               pmp_fault,
    input  logic               ls_done,
    input  logic               ls_err,
    input  logic               next_is_ls,
    input  logic               next_dep,
    input  logic [XLEN-1:0]    ex_pc,
    output logic               issue_stall,
    output logic               precise_mode,
    output logic               trap_valid,
    output logic [XLEN-1:0]    trap_epc,
    output logic [XLEN-1:0]    trap_tval,
    output logic [CAUSE_W-1:0] trap_cause
);
    import bep_pkg::*;

    bep_state_e state_q, state_d;
    logic       busy;
    logic       mode_wr;
    logic       accept;
    logic       fire;
    logic       use_now;
    logic       use_ex;
    logic       unused_wdata_bits;

    assign mode_wr           = csr_we && (csr_addr == CSR_AW'(HINT_ADDR));
    assign unused_wdata_bits = ^csr_wdata;
    assign busy              = (state_q == ST_WAIT_PREC) || (state_q == ST_WAIT_IMPR);

    bep_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .wr_val   (csr_wdata[MODE_BIT]),
        .busy     (busy),
        .mode_eff (precise_mode)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ls_start) begin
                    if (pmp_fault)         state_d = ST_TRAP;
                    else if (precise_mode) state_d = ST_WAIT_PREC;
                    else                   state_d = ST_WAIT_IMPR;
                end
            end
            ST_WAIT_PREC, ST_WAIT_IMPR: begin
                if (ls_err)       state_d = ST_TRAP;
                else if (ls_done) state_d = ST_IDLE;
            end
            ST_TRAP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        issue_stall = 1'b0;
        trap_valid  = 1'b0;
        accept      = 1'b0;
        fire        = 1'b0;
        use_now     = 1'b0;
        use_ex      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept  = ls_start && !pmp_fault;
                fire    = ls_start && pmp_fault;
                use_now = 1'b1;
            end
            ST_WAIT_PREC: begin
                issue_stall = 1'b1;
                fire        = ls_err;
            end
            ST_WAIT_IMPR: begin
                issue_stall = next_is_ls || next_dep;
                fire        = ls_err;
                use_ex      = 1'b1;
            end
            ST_TRAP: begin
                issue_stall = 1'b1;
                trap_valid  = 1'b1;
            end
            default: ;
        endcase
    end

    bep_fault_latch #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (accept),
        .cap_pc    (ls_pc),
        .cap_addr  (ls_addr),
        .cap_store (ls_store),
        .fire      (fire),
        .use_now   (use_now),
        .use_ex    (use_ex),
        .ex_pc     (ex_pc),
        .epc       (trap_epc),
        .tval      (trap_tval),
        .cause     (trap_cause)
    );

endmodule

// File: rtl/bep_checker.sv
module bep_checker #(
    parameter int unsigned XLEN = 32
) (
    input logic                clk,
    input logic                rst_n,
    input bep_pkg::bep_state_e state_q,
    input logic                ls_start,
    input logic                pmp_fault,
    input logic                ls_done,
    input logic                ls_err,
    input logic                next_is_ls,
    input logic                next_dep,
    input logic [XLEN-1:0]     ls_pc,
    input logic [XLEN-1:0]     ls_addr,
    input logic [XLEN-1:0]     ex_pc,
    input logic                issue_stall,
    input logic                precise_mode,
    input logic                trap_valid,
    input logic [XLEN-1:0]     trap_epc,
    input logic [XLEN-1:0]     trap_tval
);
    import bep_pkg::*;

    a_r3_precise_holds_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_PREC) |-> issue_stall);

    a_r4_imprecise_lets_independent_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_IMPR && !next_is_ls && !next_dep) |-> !issue_stall);

    a_r6_imprecise_epc_from_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_IMPR && ls_err) |=> (trap_valid && trap_epc == $past(ex_pc)));

    a_r7_pmp_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ls_start && pmp_fault)
        |=> (trap_valid && trap_epc == $past(ls_pc) && trap_tval == $past(ls_addr)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    a_r9_stall_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> issue_stall);

    a_r10_mode_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_PREC || state_q == ST_WAIT_IMPR) && !ls_done && !ls_err)
        |=> $stable(precise_mode));

    a_r11_ok_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_PREC || state_q == ST_WAIT_IMPR) && ls_done && !ls_err)
        |=> !trap_valid);

endmodule

bind buserr_precision_ctrl bep_checker #(.XLEN(XLEN)) u_bep_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .ls_start     (ls_start),
    .pmp_fault    (pmp_fault),
    .ls_done      (ls_done),
    .ls_err       (ls_err),
    .next_is_ls   (next_is_ls),
    .next_dep     (next_dep),
    .ls_pc        (ls_pc),
    .ls_addr      (ls_addr),
    .ex_pc        (ex_pc),
    .issue_stall  (issue_stall),
    .precise_mode (precise_mode),
    .trap_valid   (trap_valid),
    .trap_epc     (trap_epc),
    .trap_tval    (trap_tval)
);

// File: tb/tb_buserr_precision_ctrl.sv
module tb_buserr_precision_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        ls_start = 1'b0;
    logic        ls_store = 1'b0;
    logic [31:0] ls_pc = '0;
    logic [31:0] ls_addr = '0;
    logic        pmp_fault = 1'b0;
    logic        ls_done = 1'b0;
    logic        ls_err = 1'b0;
    logic        next_is_ls = 1'b0;
    logic        next_dep = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        issue_stall;
    logic        precise_mode;
    logic        trap_valid;
    logic [31:0] trap_epc;
    logic [31:0] trap_tval;
    logic [3:0]  trap_cause;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  exp_mode = 1'b1;
    bit  done_flag = 1'b0;

    always #10 clk = ~clk;

    buserr_precision_ctrl dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .ls_start(ls_start), .ls_store(ls_store),
        .ls_pc(ls_pc), .ls_addr(ls_addr), .pmp_fault(pmp_fault),
        .ls_done(ls_done), .ls_err(ls_err), .next_is_ls(next_is_ls),
        .next_dep(next_dep), .ex_pc(ex_pc), .issue_stall(issue_stall),
        .precise_mode(precise_mode), .trap_valid(trap_valid),
        .trap_epc(trap_epc), .trap_tval(trap_tval), .trap_cause(trap_cause)
    );

    function automatic logic [3:0] exp_cause(input bit st);
        return st ? 4'd7 : 4'd5;
    endfunction

    function automatic bit exp_wait_stall(input bit prec, input bit nls, input bit dep);
        return prec ? 1'b1 : (nls | dep);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_mode(input logic [11:0] addr, input bit val);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_addr  = addr;
        csr_wdata = $urandom;
        csr_wdata[20] = val;
        @(negedge clk);
        csr_we = 1'b0;
        if (addr == 12'h7C5) exp_mode = val;
        #1 check(precise_mode == exp_mode, "R2 mode", precise_mode, exp_mode);
    endtask

    // One access; lat >= 1 cycles outstanding before the response
    task automatic access(input bit pmp, input bit err, input int lat, input bit st);
        logic [31:0] pc;
        logic [31:0] ad;
        logic [31:0] last_ex;
        bit          m;
        pc = $urandom; ad = $urandom; last_ex = '0; m = exp_mode;
        @(negedge clk);
        ls_start = 1'b1; ls_pc = pc; ls_addr = ad; ls_store = st; pmp_fault = pmp;
        next_is_ls = 1'b0; next_dep = 1'b0;
        #1 check(issue_stall == 1'b0, "R3 idle no stall", issue_stall, 0);
        @(negedge clk);
        ls_start = 1'b0; pmp_fault = 1'b0;
        if (pmp) begin
            #1;
            check(trap_valid == 1'b1, "R7 pmp trap", trap_valid, 1);
            check(trap_epc == pc, "R7 pmp epc", trap_epc, pc);
            check(trap_tval == ad, "R8 tval", trap_tval, ad);
            check(trap_cause == exp_cause(st), "R8 cause", trap_cause, exp_cause(st));
            check(issue_stall == 1'b1, "R9 stall in trap", issue_stall, 1);
            @(negedge clk);
            #1 check(!trap_valid && !issue_stall, "R9 pulse ends",
                     {trap_valid, issue_stall}, 0);
        end else begin
            for (int i = 0; i < lat; i++) begin
                if (i != 0) @(negedge clk);
                next_is_ls = $urandom_range(0, 1);
                next_dep   = $urandom_range(0, 1);
                ex_pc      = $urandom;
                last_ex    = ex_pc;
                if (i == lat - 1) begin
                    ls_err  = err;
                    ls_done = !err;
                end
                #1 check(issue_stall == exp_wait_stall(m, next_is_ls, next_dep),
                         m ? "R3 precise stall" : "R4 imprecise stall", issue_stall,
                         exp_wait_stall(m, next_is_ls, next_dep));
            end
            @(negedge clk);
            ls_err = 1'b0; ls_done = 1'b0; next_is_ls = 1'b0; next_dep = 1'b0;
            #1;
            if (err) begin
                check(trap_valid == 1'b1, "R5/R6 trap raised", trap_valid, 1);
                check(trap_epc == (m ? pc : last_ex), m ? "R5 epc" : "R6 epc",
                      trap_epc, m ? pc : last_ex);
                check(trap_tval == ad, "R8 tval", trap_tval, ad);
                check(trap_cause == exp_cause(st), "R8 cause", trap_cause, exp_cause(st));
                check(issue_stall == 1'b1, "R9 stall in trap", issue_stall, 1);
                @(negedge clk);
                #1 check(!trap_valid && !issue_stall, "R9 pulse ends",
                         {trap_valid, issue_stall}, 0);
            end else begin
                check(!trap_valid && !issue_stall, "R11 ok no trap",
                      {trap_valid, issue_stall}, 0);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(precise_mode == 1'b1, "R1 reset mode", precise_mode, 1);
        check(issue_stall == 1'b0, "R1 reset stall", issue_stall, 0);
        check(trap_valid == 1'b0, "R1 reset trap", trap_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: precise mode
        access(1'b0, 1'b1, 3, 1'b0);
        access(1'b1, 1'b0, 1, 1'b1);
        access(1'b0, 1'b0, 2, 1'b1);

        // R2: foreign address ignored, then real switch
        write_mode(12'h7C4, 1'b0);
        write_mode(12'h7C5, 1'b0);

        // Directed: imprecise mode
        access(1'b0, 1'b1, 4, 1'b1);
        access(1'b1, 1'b0, 1, 1'b0);
        access(1'b0, 1'b0, 1, 1'b0);

        // R10: deferred mode write
        @(negedge clk);
        ls_start = 1'b1; ls_pc = 32'h100; ls_addr = 32'h2000; ls_store = 1'b0;
        @(negedge clk);
        ls_start = 1'b0;
        csr_we = 1'b1; csr_addr = 12'h7C5; csr_wdata = 32'h0010_0000;
        @(negedge clk);
        csr_we = 1'b0; next_is_ls = 1'b0; next_dep = 1'b0;
        #1;
        check(precise_mode == 1'b0, "R10 mode held", precise_mode, 0);
        check(issue_stall == 1'b0, "R10 old rule kept", issue_stall, 0);
        @(negedge clk);
        ls_done = 1'b1;
        #1 check(precise_mode == 1'b0, "R10 mode held at done", precise_mode, 0);
        @(negedge clk);
        ls_done = 1'b0;
        #1 check(precise_mode == 1'b1, "R10 mode applied", precise_mode, 1);
        exp_mode = 1'b1;

        // Random mix
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 3) == 0)
                write_mode($urandom_range(0, 1) ? 12'h7C5 : 12'h7C0 + 12'($urandom_range(0, 3)),
                           $urandom_range(0, 1));
            access($urandom_range(0, 4) == 0, $urandom_range(0, 1),
                   $urandom_range(1, 6), $urandom_range(0, 1));
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule